// File: doc/BRIEF.md
# Burst-aligning transfer address generator

This block produces the command stream for a DMA-style master that moves a block of words starting at any word address. A burst boundary is a byte address that is a multiple of MAX_BURST times BYTES_PER_BEAT. For example, a maximum burst of 2 beats on a 4-byte bus gives 8-byte boundaries. The generator guarantees that a command never crosses such a boundary, so a downstream memory port that wraps bursts at its boundary never has to split them.

After a start pulse, the generator works in phases. While the current address sits off a boundary, it issues single-beat commands to walk the address forward. Once the address is aligned, it issues full-length bursts back to back. Any remainder smaller than a full burst goes out as single beats. Each command is presented with a valid/ready handshake and advances the address by its beat count times the bus width in bytes. A one-cycle done pulse marks the end of the transfer. An aligned flag tells the fabric that the current command, and every one after it in the transfer, starts on a boundary or continues a boundary-started tail.

Top module: `burst_align_gen`

## Requirements
- R1: After synchronous reset, cmd_valid_o, done_o and aligned_o are low, and the block accepts a new start.
- R2: While the current address is not a multiple of MAX_BURST*BYTES_PER_BEAT and realignment is not finished, every command has cmd_burst_o = 1.
- R3: Once the address is on a boundary and at least MAX_BURST words remain, the command has cmd_burst_o = MAX_BURST, and such bursts follow one another with no idle cycle while cmd_ready_i is high.
- R4: When fewer than MAX_BURST words remain at an aligned address, the rest of the transfer is issued as commands with cmd_burst_o = 1.
- R5: If the length is smaller than the number of single beats needed to reach a boundary, exactly that many single-beat commands are issued and the transfer completes.
- R6: Each accepted command moves the next command address up by cmd_burst_o*BYTES_PER_BEAT bytes, and the burst counts of a transfer sum to its length.
- R7: While cmd_valid_o is high and cmd_ready_i is low, cmd_valid_o, cmd_addr_o and cmd_burst_o hold their values.
- R8: done_o is high for exactly one cycle, the cycle after the last command is accepted, and cmd_valid_o is low in that cycle.
- R9: aligned_o is low during realignment and is high with every command from the first one issued at an aligned address to the last one of the transfer. It is low while idle and in the done cycle, and a full-length burst is never presented with aligned_o low.
- R10: A start pulse while a transfer is in progress, including the done cycle, is ignored.
- R11: A start with length zero issues no command and pulses done_o in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, sampled when idle |
| start_addr_i | input | ADDR_W | Byte address of the first word (word aligned) |
| start_len_i | input | LEN_W | Transfer length in words |
| cmd_valid_o | output | 1 | Command present |
| cmd_ready_i | input | 1 | Command accepted when high with valid |
| cmd_addr_o | output | ADDR_W | Byte address of the command |
| cmd_burst_o | output | $clog2(MAX_BURST+1) | Beats in the command |
| aligned_o | output | 1 | Realignment finished for this transfer |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The bench builds the block with MAX_BURST = 4 and BYTES_PER_BEAT = 4, giving a 16-byte boundary. With a boundary that small, realignment runs of one to three single beats, a tail after a single full burst, and a transfer that ends before alignment all fit in a handful of words. Table vectors mix steady and intermittent ready so that command holding is exercised in every phase. Directed cases cover zero length and start pulses during a busy transfer and during the done cycle.

// File: rtl/bag_pkg.sv
package bag_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ALIGN,
    PH_BURST,
    PH_TAIL,
    PH_DONE
  } phase_t;
endpackage

// File: rtl/bag_boundary.sv
// Flags whether an address offset sits on a burst boundary.
module bag_boundary #(
  parameter int OFF_W = 4
) (
  input  logic [OFF_W-1:0] addr_lo,
  output logic             on_bound
);
  assign on_bound = (addr_lo == '0);
endmodule

// File: rtl/bag_phase_sel.sv
// Chooses the next phase and beat count from the remaining length and alignment.
module bag_phase_sel
  import bag_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int MAX_BURST = 8,
  parameter int BCNT_W    = 4
) (
  input  logic              on_bound,
  input  logic              stay_tail,
  input  logic [LEN_W-1:0]  rem,
  output phase_t            phase,
  output logic [BCNT_W-1:0] bcnt
);
  localparam logic [LEN_W-1:0]  FULL_LEN = LEN_W'(MAX_BURST);
  localparam logic [BCNT_W-1:0] FULL_CNT = BCNT_W'(MAX_BURST);

  always_comb begin
    phase = PH_DONE;
    bcnt  = BCNT_W'(1);
    if (rem == '0) begin
      phase = PH_DONE;
    end else if (stay_tail) begin
      phase = PH_TAIL;
    end else if (!on_bound) begin
      phase = PH_ALIGN;
    end else if (rem >= FULL_LEN) begin
      phase = PH_BURST;
      bcnt  = FULL_CNT;
    end else begin
      phase = PH_TAIL;
    end
  end
endmodule

// File: rtl/burst_align_gen.sv
module burst_align_gen
  import bag_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int LEN_W          = 16,
  parameter int MAX_BURST      = 8,
  parameter int BYTES_PER_BEAT = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             start_i,
  input  logic [ADDR_W-1:0]                start_addr_i,
  input  logic [LEN_W-1:0]                 start_len_i,
  output logic                             cmd_valid_o,
  input  logic                             cmd_ready_i,
  output logic [ADDR_W-1:0]                cmd_addr_o,
  output logic [$clog2(MAX_BURST+1)-1:0]   cmd_burst_o,
  output logic                             aligned_o,
  output logic                             done_o
);
  localparam int BOUND_BYTES = MAX_BURST * BYTES_PER_BEAT;
  localparam int OFF_W       = $clog2(BOUND_BYTES);
  localparam int BCNT_W      = $clog2(MAX_BURST + 1);

  phase_t              phase_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [LEN_W-1:0]    rem_q;
  logic [BCNT_W-1:0]   bcnt_q;
  logic                valid_q;
  logic                aligned_q;
  logic                done_q;

  logic                launch;
  logic                accept;
  logic                load;
  logic [ADDR_W-1:0]   cand_addr;
  logic [LEN_W-1:0]    cand_rem;
  logic                cand_on_bound;
  phase_t              sel_phase;
  logic [BCNT_W-1:0]   sel_bcnt;

  assign launch = start_i && (phase_q == PH_IDLE);
  assign accept = valid_q && cmd_ready_i;
  assign load   = launch || accept;

  always_comb begin
    if (launch) begin
      cand_addr = start_addr_i;
      cand_rem  = start_len_i;
    end else begin
      cand_addr = addr_q + ADDR_W'(bcnt_q) * ADDR_W'(BYTES_PER_BEAT);
      cand_rem  = rem_q - LEN_W'(bcnt_q);
    end
  end

  bag_boundary #(.OFF_W(OFF_W)) u_bound (
    .addr_lo  (cand_addr[OFF_W-1:0]),
    .on_bound (cand_on_bound)
  );

  bag_phase_sel #(
    .LEN_W     (LEN_W),
    .MAX_BURST (MAX_BURST),
    .BCNT_W    (BCNT_W)
  ) u_sel (
    .on_bound  (cand_on_bound),
    .stay_tail (!launch && (phase_q == PH_TAIL)),
    .rem       (cand_rem),
    .phase     (sel_phase),
    .bcnt      (sel_bcnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      addr_q    <= '0;
      rem_q     <= '0;
      bcnt_q    <= '0;
      valid_q   <= 1'b0;
      aligned_q <= 1'b0;
      done_q    <= 1'b0;
    end else if (phase_q == PH_DONE) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else if (load) begin
      phase_q   <= sel_phase;
      addr_q    <= cand_addr;
      rem_q     <= cand_rem;
      bcnt_q    <= sel_bcnt;
      valid_q   <= (sel_phase != PH_DONE);
      aligned_q <= (sel_phase == PH_BURST) || (sel_phase == PH_TAIL);
      done_q    <= (sel_phase == PH_DONE);
    end
  end

  assign cmd_valid_o = valid_q;
  assign cmd_addr_o  = addr_q;
  assign cmd_burst_o = bcnt_q;
  assign aligned_o   = aligned_q;
  assign done_o      = done_q;
endmodule

// File: rtl/bag_checker.sv
module bag_checker #(
  parameter int ADDR_W         = 32,
  parameter int MAX_BURST      = 8,
  parameter int BYTES_PER_BEAT = 8
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           cmd_valid,
  input logic                           cmd_ready,
  input logic [ADDR_W-1:0]              cmd_addr,
  input logic [$clog2(MAX_BURST+1)-1:0] cmd_burst,
  input logic                           aligned,
  input logic                           done
);
  localparam int OFF_W  = $clog2(MAX_BURST * BYTES_PER_BEAT);
  localparam int BCNT_W = $clog2(MAX_BURST + 1);

  AST_OFFBOUND_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_addr[OFF_W-1:0] != '0) |-> cmd_burst == BCNT_W'(1)); // R2
  AST_FULL_ON_BOUND: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_burst == BCNT_W'(MAX_BURST)) |-> cmd_addr[OFF_W-1:0] == '0); // R3
  AST_BURST_KIND: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_burst == BCNT_W'(1) || cmd_burst == BCNT_W'(MAX_BURST))); // R4
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> (!cmd_valid ||
      cmd_addr == $past(cmd_addr) + ADDR_W'($past(cmd_burst)) * ADDR_W'(BYTES_PER_BEAT))); // R6
  AST_HOLD_CMD: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_burst))); // R7
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done |-> !cmd_valid); // R8
  AST_ALIGNED_BUSY: assert property (@(posedge clk) disable iff (rst)
    aligned |-> cmd_valid); // R9
  AST_FULL_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_burst == BCNT_W'(MAX_BURST)) |-> aligned); // R9
endmodule

bind burst_align_gen bag_checker #(
  .ADDR_W         (ADDR_W),
  .MAX_BURST      (MAX_BURST),
  .BYTES_PER_BEAT (BYTES_PER_BEAT)
) u_bag_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid_o),
  .cmd_ready (cmd_ready_i),
  .cmd_addr  (cmd_addr_o),
  .cmd_burst (cmd_burst_o),
  .aligned   (aligned_o),
  .done      (done_o)
);

// File: tb/tb_burst_align_gen.sv
`timescale 1ns/1ps
module tb_burst_align_gen;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int MAXB   = 4;
  localparam int BPB    = 4;
  localparam int BOUND  = MAXB * BPB;
  localparam int BW     = $clog2(MAXB + 1);
  localparam int NVEC   = 7;

  // {start address, length, expected command count, aligned seen}
  localparam logic [56:0] VEC [NVEC] = '{
    {32'h0000_0000, 16'd8,  8'd2, 1'b1},
    {32'h0000_0004, 16'd10, 8'd7, 1'b1},
    {32'h0000_000C, 16'd2,  8'd2, 1'b1},
    {32'h0000_0008, 16'd1,  8'd1, 1'b0},
    {32'h0000_0014, 16'd11, 8'd5, 1'b1},
    {32'h0000_0030, 16'd3,  8'd3, 1'b1},
    {32'h0000_0004, 16'd3,  8'd3, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [ADDR_W-1:0] start_addr_i = '0;
  logic [LEN_W-1:0]  start_len_i = '0;
  logic cmd_ready_i = 1'b1;
  logic cmd_valid_o, aligned_o, done_o;
  logic [ADDR_W-1:0] cmd_addr_o;
  logic [BW-1:0]     cmd_burst_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  burst_align_gen #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_BURST(MAXB), .BYTES_PER_BEAT(BPB)
  ) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .start_addr_i(start_addr_i),
    .start_len_i(start_len_i), .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
    .cmd_addr_o(cmd_addr_o), .cmd_burst_o(cmd_burst_o), .aligned_o(aligned_o),
    .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [31:0] a, input logic [15:0] l);
    start_addr_i = a;
    start_len_i  = l;
    start_i      = 1'b1;
    @(negedge clk);
    start_i      = 1'b0;
  endtask

  // Runs one transfer and checks every command against a model of R2-R9.
  task automatic run_vec(input logic [31:0] a, input logic [15:0] l,
                         input int exp_n, input bit exp_al, input bit gappy);
    logic [31:0] m_addr = a;
    int  m_rem = l;
    bit  past = 0, tail = 0, seen = 0;
    int  ncmd = 0, guard = 0, b = 0;
    cmd_ready_i = 1'b1;
    @(negedge clk);
    pulse_start(a, l);
    while (m_rem > 0 && guard < 500) begin
      guard++;
      if (!past && (m_addr % BOUND) != 0) b = 1;
      else begin
        past = 1;
        if (!tail && m_rem >= MAXB) b = MAXB;
        else begin tail = 1; b = 1; end
      end
      cmd_ready_i = gappy ? (guard % 3 != 0) : 1'b1;
      chk(cmd_valid_o == 1'b1, "R3 valid", 32'(cmd_valid_o), 1);
      chk(cmd_addr_o == m_addr, "R6 address", cmd_addr_o, m_addr);
      chk(cmd_burst_o == BW'(b), (b == MAXB) ? "R3 burst" : (past ? "R4 burst" : "R2 burst"),
          32'(cmd_burst_o), b);
      chk(aligned_o == past, "R9 aligned", 32'(aligned_o), 32'(past));
      if (aligned_o) seen = 1;
      @(negedge clk);
      if (cmd_ready_i) begin
        m_addr += b * BPB;
        m_rem  -= b;
        ncmd++;
      end else begin
        chk(cmd_valid_o && cmd_addr_o == m_addr, "R7 hold", cmd_addr_o, m_addr);
      end
    end
    cmd_ready_i = 1'b1;
    chk(done_o == 1'b1, "R8 done pulse", 32'(done_o), 1);
    chk(cmd_valid_o == 1'b0, "R8 valid low", 32'(cmd_valid_o), 0);
    chk(aligned_o == 1'b0, "R9 aligned low at done", 32'(aligned_o), 0);
    chk(ncmd == exp_n, (exp_al ? "R6 count" : "R5 count"), ncmd, exp_n);
    chk(seen == exp_al, "R9 aligned seen", 32'(seen), 32'(exp_al));
    @(negedge clk);
    chk(done_o == 1'b0, "R8 single cycle", 32'(done_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!cmd_valid_o && !done_o && !aligned_o, "R1 reset state",
        {cmd_valid_o, done_o, aligned_o}, 0);

    for (int i = 0; i < NVEC; i++) begin
      run_vec(VEC[i][56:25], VEC[i][24:9], int'(VEC[i][8:1]), VEC[i][0], i[0]);
    end

    // R11: zero length
    pulse_start(32'h20, 16'd0);
    chk(done_o && !cmd_valid_o, "R11 zero length done", {done_o, cmd_valid_o}, 2);
    @(negedge clk);
    chk(!done_o && !cmd_valid_o, "R11 no command", {done_o, cmd_valid_o}, 0);

    // R10: start while busy and during the done cycle
    cmd_ready_i = 1'b0;
    pulse_start(32'h40, 16'd4);
    chk(cmd_addr_o == 32'h40 && cmd_burst_o == BW'(MAXB), "R3 full burst at boundary",
        cmd_addr_o, 32'h40);
    pulse_start(32'h104, 16'd2);
    chk(cmd_addr_o == 32'h40 && cmd_burst_o == BW'(MAXB), "R10 busy start ignored",
        cmd_addr_o, 32'h40);
    cmd_ready_i = 1'b1;
    @(negedge clk);
    chk(done_o == 1'b1, "R8 done after burst", 32'(done_o), 1);
    pulse_start(32'h104, 16'd2);
    chk(!cmd_valid_o && !done_o, "R10 start in done cycle ignored",
        {cmd_valid_o, done_o}, 0);
    @(negedge clk);
    chk(!cmd_valid_o, "R10 still idle", 32'(cmd_valid_o), 0);

    // R1: reset in the middle of a transfer
    cmd_ready_i = 1'b0;
    pulse_start(32'h4, 16'd9);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!cmd_valid_o && !done_o && !aligned_o, "R1 reset mid transfer",
        {cmd_valid_o, done_o, aligned_o}, 0);
    cmd_ready_i = 1'b1;
    run_vec(32'h0, 16'd4, 1, 1'b1, 1'b0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule